// File: doc/BRIEF.md
# Push-Button Rail Bring-Up Sequencer

This controller turns a single key press into an ordered power-up of six supply enables. While the system is off it watches only an active-low button line. A press must stay low for a full debounce window before it is accepted. Acceptance is signalled on an active-low key-press output, and the sequence starts at that moment. An auxiliary external regulator is enabled first. After a short lead delay, the second linear regulator and the third switching converter are enabled together. When the second linear regulator reports power good, the first and second switching converters follow.

From that final stage, two things proceed independently. The first linear regulator is enabled once the processor raises its go input. The processor reset is released a fixed hold time after the first switching converter reports good. All delays are counted on a one-millisecond tick input that is synchronous to the clock. The button, the power-good lines and the processor go line are asynchronous and pass through synchronizers. If the second linear regulator never reports good within a timeout, every enable drops and the controller returns to off.

Top module: `rail_bringup_seq`

## Requirements
- R1: After reset, every enable output is low, `key_no` is high and `proc_rst_no` is low.
- R2: A press is accepted on the 50th tick that arrives while the button stays low (low level = pressed). `aux_en_o` and no other enable rises at acceptance, and 49 ticks are not enough.
- R3: If the button returns high during the debounce window, the controller goes back to off with all enables low. A later press starts a new full 50-tick count.
- R4: `key_no` falls in the same cycle that `aux_en_o` rises, and returns high once the released button has passed the synchronizer. Releasing the button has no effect on the enables.
- R5: `lin2_en_o` and `sw3_en_o` rise together on the first tick after acceptance, with `aux_en_o` already high.
- R6: `sw1_en_o` and `sw2_en_o` stay low until `lin2_good_i` is high, and then rise together.
- R7: If `lin2_good_i` is not seen within 100 ticks of `lin2_en_o` rising, all enables drop on the 100th tick and the controller is off again. 99 ticks are not enough.
- R8: `lin1_en_o` rises only in the final stage (`sw1_en_o` high) when `host_go_i` is high, and it then stays high when `host_go_i` falls. `host_go_i` raised earlier has no effect until that stage.
- R9: `proc_rst_no` goes high on the 20th tick counted in the final stage while `sw1_good_i` is high, not on the 19th, and it then stays high.
- R10: A low on `sw1_good_i` before release clears the reset hold count, so a full 20 ticks are needed afterwards.
- R11: A `host_go_i` rise and the 20th hold tick that land in the same cycle take effect together: `lin1_en_o` and `proc_rst_no` both rise on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse every millisecond, synchronous to clk_i |
| key_ni | input | 1 | Push button, low while pressed, asynchronous |
| lin2_good_i | input | 1 | Power good of linear regulator 2, asynchronous |
| sw1_good_i | input | 1 | Power good of switching converter 1, asynchronous |
| host_go_i | input | 1 | Processor request to enable linear regulator 1, asynchronous |
| key_no | output | 1 | Accepted key press, low while held after acceptance |
| aux_en_o | output | 1 | Enable of the external auxiliary regulator |
| lin1_en_o | output | 1 | Enable of linear regulator 1 |
| lin2_en_o | output | 1 | Enable of linear regulator 2 |
| sw1_en_o | output | 1 | Enable of switching converter 1 |
| sw2_en_o | output | 1 | Enable of switching converter 2 |
| sw3_en_o | output | 1 | Enable of switching converter 3 |
| proc_rst_no | output | 1 | Processor reset, low while held |

## Verification
In the final stage, the processor-driven enable of linear regulator 1 and the timed reset release are produced by separate logic. Both can change on the same clock edge. The bench provokes this by raising `host_go_i` two cycles before it delivers the 20th hold tick, so that the synchronized go level and the tick reach their registers at the same edge. It then checks that both outputs are still low one cycle before that edge and both high right after it. Button release against acceptance is the other race. The debounce test releases the button partway through the window and then shows that the next press needs a fresh full count.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_DEBOUNCE = 3'd1,
    ST_LEAD     = 3'd2,
    ST_WAIT_L2  = 3'd3,
    ST_RUN      = 3'd4
  } seq_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rbs_sync.sv
module rbs_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q[s] <= RST_VAL;
      end else begin
        if (s == 0) pipe_q[s] <= d_i;
        else        pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rbs_tick_timer.sv
module rbs_tick_timer #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         tick_i,
  output logic [W-1:0] count_o
);

  localparam logic [W-1:0] CntMax = '1;

  logic [W-1:0] cnt_q;

  // saturating tick counter, clear has priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clear_i)                    cnt_q <= '0;
    else if (tick_i && cnt_q != CntMax)  cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/rbs_fsm.sv
module rbs_fsm
  import rbs_pkg::*;
#(
  parameter int unsigned DEBOUNCE_TICKS = 50,
  parameter int unsigned LEAD_TICKS     = 1,
  parameter int unsigned TIMEOUT_TICKS  = 100,
  parameter int unsigned CNT_W          = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             key_s_i,
  input  logic             lin2_good_s_i,
  input  logic             host_go_s_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             tmr_clear_o,
  output seq_state_e       state_o,
  output logic             key_no,
  output logic             lin1_en_o
);

  localparam logic [CNT_W-1:0] DebLast  = CNT_W'(DEBOUNCE_TICKS - 1);
  localparam logic [CNT_W-1:0] LeadLast = CNT_W'(LEAD_TICKS - 1);
  localparam logic [CNT_W-1:0] ToLast   = CNT_W'(TIMEOUT_TICKS - 1);

  seq_state_e state_q, state_d;
  logic       key_n_q, lin1_q;
  logic       accept;

  always_comb begin
    state_d     = state_q;
    tmr_clear_o = 1'b0;
    accept      = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        tmr_clear_o = 1'b1;
        if (!key_s_i) state_d = ST_DEBOUNCE;
      end
      ST_DEBOUNCE: begin
        // release beats a coincident final tick
        if (key_s_i) begin
          state_d     = ST_OFF;
          tmr_clear_o = 1'b1;
        end else if (tick_i && count_i == DebLast) begin
          state_d     = ST_LEAD;
          tmr_clear_o = 1'b1;
          accept      = 1'b1;
        end
      end
      ST_LEAD: begin
        if (tick_i && count_i == LeadLast) begin
          state_d     = ST_WAIT_L2;
          tmr_clear_o = 1'b1;
        end
      end
      ST_WAIT_L2: begin
        if (lin2_good_s_i) begin
          state_d     = ST_RUN;
          tmr_clear_o = 1'b1;
        end else if (tick_i && count_i == ToLast) begin
          state_d     = ST_OFF;
          tmr_clear_o = 1'b1;
        end
      end
      ST_RUN: begin
        tmr_clear_o = 1'b1;
      end
      default: begin
        state_d     = ST_OFF;
        tmr_clear_o = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      key_n_q <= 1'b1;
      lin1_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept)       key_n_q <= 1'b0;
      else if (key_s_i) key_n_q <= 1'b1;
      if (state_q != ST_RUN) lin1_q <= 1'b0;
      else if (host_go_s_i)  lin1_q <= 1'b1;
    end
  end

  assign state_o   = state_q;
  assign key_no    = key_n_q;
  assign lin1_en_o = lin1_q;

endmodule

// File: rtl/rbs_rst_gen.sv
module rbs_rst_gen #(
  parameter int unsigned HOLD_TICKS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic good_s_i,
  output logic rst_no
);

  localparam int unsigned HoldW = $clog2(HOLD_TICKS + 1);
  localparam logic [HoldW-1:0] HoldLast = HoldW'(HOLD_TICKS - 1);

  logic             released_q;
  logic [HoldW-1:0] cnt;
  logic             clr;

  assign clr = !run_i || !good_s_i || released_q;

  rbs_tick_timer #(.W(HoldW)) u_hold_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clr),
    .tick_i  (tick_i),
    .count_o (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   released_q <= 1'b0;
    else if (!run_i)                               released_q <= 1'b0;
    else if (good_s_i && tick_i && cnt == HoldLast) released_q <= 1'b1;
  end

  assign rst_no = released_q;

endmodule

// File: rtl/rail_bringup_seq.sv
module rail_bringup_seq
  import rbs_pkg::*;
#(
  parameter int unsigned DEBOUNCE_TICKS = 50,
  parameter int unsigned LEAD_TICKS     = 1,
  parameter int unsigned TIMEOUT_TICKS  = 100,
  parameter int unsigned HOLD_TICKS     = 20,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic key_ni,
  input  logic lin2_good_i,
  input  logic sw1_good_i,
  input  logic host_go_i,
  output logic key_no,
  output logic aux_en_o,
  output logic lin1_en_o,
  output logic lin2_en_o,
  output logic sw1_en_o,
  output logic sw2_en_o,
  output logic sw3_en_o,
  output logic proc_rst_no
);

  localparam int unsigned MaxTicks = max3(DEBOUNCE_TICKS, LEAD_TICKS, TIMEOUT_TICKS);
  localparam int unsigned CntW     = $clog2(MaxTicks + 1);
  localparam int unsigned NumAsync = 4;

  logic [NumAsync-1:0] async_raw, async_s;
  logic                key_s, lin2_good_s, sw1_good_s, host_go_s;
  logic [CntW-1:0]     seq_cnt;
  logic                seq_clr;
  seq_state_e          state;

  assign async_raw = {host_go_i, sw1_good_i, lin2_good_i, key_ni};

  rbs_sync #(
    .WIDTH   (NumAsync),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b0001)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (async_raw),
    .q_o    (async_s)
  );

  assign key_s       = async_s[0];
  assign lin2_good_s = async_s[1];
  assign sw1_good_s  = async_s[2];
  assign host_go_s   = async_s[3];

  rbs_tick_timer #(.W(CntW)) u_seq_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (seq_clr),
    .tick_i  (tick_i),
    .count_o (seq_cnt)
  );

  rbs_fsm #(
    .DEBOUNCE_TICKS (DEBOUNCE_TICKS),
    .LEAD_TICKS     (LEAD_TICKS),
    .TIMEOUT_TICKS  (TIMEOUT_TICKS),
    .CNT_W          (CntW)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .key_s_i       (key_s),
    .lin2_good_s_i (lin2_good_s),
    .host_go_s_i   (host_go_s),
    .count_i       (seq_cnt),
    .tmr_clear_o   (seq_clr),
    .state_o       (state),
    .key_no        (key_no),
    .lin1_en_o     (lin1_en_o)
  );

  rbs_rst_gen #(.HOLD_TICKS(HOLD_TICKS)) u_rst_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (state == ST_RUN),
    .good_s_i (sw1_good_s),
    .rst_no   (proc_rst_no)
  );

  assign aux_en_o  = (state == ST_LEAD) || (state == ST_WAIT_L2) || (state == ST_RUN);
  assign lin2_en_o = (state == ST_WAIT_L2) || (state == ST_RUN);
  assign sw3_en_o  = lin2_en_o;
  assign sw1_en_o  = (state == ST_RUN);
  assign sw2_en_o  = sw1_en_o;

endmodule

// File: rtl/rail_bringup_seq_chk.sv
module rail_bringup_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic key_no,
  input logic aux_en_o,
  input logic lin1_en_o,
  input logic lin2_en_o,
  input logic sw1_en_o,
  input logic sw2_en_o,
  input logic sw3_en_o,
  input logic proc_rst_no
);

  p_key_with_aux_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(key_no) |-> $rose(aux_en_o));

  p_aux_needs_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aux_en_o) |-> !key_no);

  p_aux_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lin2_en_o |-> (aux_en_o && sw3_en_o));

  p_lin2_after_aux_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lin2_en_o) |-> $past(aux_en_o));

  p_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw1_en_o |-> (sw2_en_o && lin2_en_o));

  p_lin1_stage_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lin1_en_o |-> sw1_en_o);

  p_lin1_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lin1_en_o && sw1_en_o) |=> (lin1_en_o || !sw1_en_o));

  p_rst_stage_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proc_rst_no |-> sw1_en_o);

  p_rst_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_rst_no && sw1_en_o) |=> (proc_rst_no || !sw1_en_o));

  p_off_all_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aux_en_o |-> (!lin2_en_o && !sw1_en_o && !lin1_en_o && !proc_rst_no));

endmodule

bind rail_bringup_seq rail_bringup_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .key_no      (key_no),
  .aux_en_o    (aux_en_o),
  .lin1_en_o   (lin1_en_o),
  .lin2_en_o   (lin2_en_o),
  .sw1_en_o    (sw1_en_o),
  .sw2_en_o    (sw2_en_o),
  .sw3_en_o    (sw3_en_o),
  .proc_rst_no (proc_rst_no)
);

// File: tb/rail_bringup_seq_bench.sv
`timescale 1ns/1ps
module rail_bringup_seq_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic key_n = 1'b1;
  logic l2_good = 1'b0;
  logic s1_good = 1'b0;
  logic host_go = 1'b0;
  logic key_o, aux_en, lin1_en, lin2_en, sw1_en, sw2_en, sw3_en, prst_n;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  rail_bringup_seq u_rail_bringup_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .key_ni      (key_n),
    .lin2_good_i (l2_good),
    .sw1_good_i  (s1_good),
    .host_go_i   (host_go),
    .key_no      (key_o),
    .aux_en_o    (aux_en),
    .lin1_en_o   (lin1_en),
    .lin2_en_o   (lin2_en),
    .sw1_en_o    (sw1_en),
    .sw2_en_o    (sw2_en),
    .sw3_en_o    (sw3_en),
    .proc_rst_no (prst_n)
  );

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  // packed view: {key_no, aux, lin1, lin2, sw1, sw2, sw3, proc_rst_n}
  function automatic logic [7:0] outs();
    return {key_o, aux_en, lin1_en, lin2_en, sw1_en, sw2_en, sw3_en, prst_n};
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      wait_cyc(2);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; key_n = 1'b1;
    l2_good = 1'b0; s1_good = 1'b0; host_go = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
  endtask

  // press, accept and step into wait-for-lin2
  task automatic reach_wait();
    key_n = 1'b0;
    wait_cyc(4);
    give_ticks(50);
    key_n = 1'b1;
    wait_cyc(4);
    give_ticks(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset outputs", outs(), 8'b1000_0000);
  endtask

  task automatic t_bounce();
    do_reset();
    key_n = 1'b0;
    wait_cyc(4);
    give_ticks(30);
    key_n = 1'b1;
    wait_cyc(6);
    chk("R3 early release back to off", outs(), 8'b1000_0000);
    key_n = 1'b0;
    wait_cyc(4);
    give_ticks(49);
    chk("R3 new press needs full count", {7'b0, aux_en}, 8'd0);
    give_ticks(1);
    chk("R3 full recount accepted", {7'b0, aux_en}, 8'd1);
  endtask

  task automatic t_timeout();
    do_reset();
    key_n = 1'b0;
    wait_cyc(4);
    give_ticks(49);
    chk("R2 49 ticks not enough", outs(), 8'b1000_0000);
    give_ticks(1);
    chk("R2 accept, aux only", outs(), 8'b0100_0000);
    key_n = 1'b1;
    wait_cyc(4);
    chk("R4 release raises key output, enables kept", outs(), 8'b1100_0000);
    give_ticks(1);
    chk("R5 lin2 and sw3 together", outs(), 8'b1101_0010);
    give_ticks(99);
    chk("R7 99 ticks keep waiting", outs(), 8'b1101_0010);
    give_ticks(1);
    chk("R7 timeout drops all", outs(), 8'b1000_0000);
    key_n = 1'b0;
    wait_cyc(4);
    give_ticks(50);
    chk("R7 new press after timeout", {7'b0, aux_en}, 8'd1);
  endtask

  task automatic t_full();
    do_reset();
    reach_wait();
    host_go = 1'b1;
    wait_cyc(6);
    chk("R6 no sw1/sw2 before lin2 good", {6'b0, sw1_en, sw2_en}, 8'd0);
    chk("R8 host go ignored before final stage", {7'b0, lin1_en}, 8'd0);
    l2_good = 1'b1;
    wait_cyc(6);
    chk("R6 sw1/sw2 on after lin2 good", outs(), 8'b1111_1110);
    host_go = 1'b0;
    wait_cyc(6);
    chk("R8 lin1 stays after host go falls", {7'b0, lin1_en}, 8'd1);
    s1_good = 1'b1;
    wait_cyc(4);
    give_ticks(10);
    s1_good = 1'b0;
    wait_cyc(4);
    s1_good = 1'b1;
    wait_cyc(4);
    give_ticks(19);
    chk("R10 hold count restarted", {7'b0, prst_n}, 8'd0);
    give_ticks(1);
    chk("R9 reset released on 20th tick", {7'b0, prst_n}, 8'd1);
    s1_good = 1'b0;
    wait_cyc(6);
    chk("R9 release stays", {7'b0, prst_n}, 8'd1);
  endtask

  task automatic t_same_edge();
    do_reset();
    reach_wait();
    l2_good = 1'b1;
    s1_good = 1'b1;
    wait_cyc(6);
    give_ticks(19);
    chk("R9 19 hold ticks not enough", {6'b0, lin1_en, prst_n}, 8'd0);
    @(negedge clk) host_go = 1'b1;
    @(negedge clk);
    @(negedge clk) tick = 1'b1;
    chk("R11 both low before shared edge", {6'b0, lin1_en, prst_n}, 8'd0);
    @(negedge clk) tick = 1'b0;
    chk("R11 both rise on shared edge", {6'b0, lin1_en, prst_n}, 8'b11);
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_bounce();
    t_timeout();
    t_full();
    t_same_edge();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule